// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver Controller

This block holds the data-path and clock-routing logic of a wide, two-way bus transceiver. It sits between a local "A" bus and a backplane "B" bus. Four control inputs set how it behaves: a direction select, a data output-enable (active low), a clock-gate/transparent select (active high), and a capture-clock select. The pads stay outside the block. Each port has its own data-out vector and enable, and the block decides which side drives.

In registered mode, the destination port shows a stored copy of the source port. That copy is taken on a rising edge of the chosen clock, or on a falling edge of the clock-gate input. In transparent mode, the destination follows the source directly and both forwarded-clock outputs are off. When transmitting, the system clock goes out on the source-synchronous clock pin and on the local clock output. When receiving, the capture clock can be the incoming source-synchronous clock or the local system clock.

The system clock and the incoming source-synchronous clock are treated as slow strobes. They are sampled by a fast core clock, and their rising edges are found by comparison with the previous sample. A capture takes effect at the core-clock edge on which the strobe is first seen high.

Top module: `bus_xcvr_ctl`

## Requirements
- R1: With `dirSel`=0 and `oeN`=0, B is the destination (`bOe`=1, `aOe`=0). With `dirSel`=1 and `oeN`=0, A is the destination (`aOe`=1, `bOe`=0). Data is never inverted.
- R2: With `gateHi`=0 and `oeN`=0, the destination shows the stored word. The word loads at the core-clock edge where the selected clock is first sampled high. Otherwise the word holds.
- R3: With `gateHi`=1 and `oeN`=0, the destination output equals the source input in the same cycle, and `ssClkOe`=0 and `clkOutOe`=0.
- R4: With `oeN`=1 and `gateHi`=0, `aOe`=0 and `bOe`=0, both clock enables stay 1, and selected-clock edges still load the storage word.
- R5: With `oeN`=1 and `gateHi`=1, all four enables (`aOe`, `bOe`, `ssClkOe`, `clkOutOe`) are 0.
- R6: With `dirSel`=0 and `gateHi`=0, `ssClkOut` and `clkOut` both equal `sysClk`, and both clock enables are 1, whatever `capSel` is.
- R7: With `dirSel`=1 and `capSel`=0, `ssClkOe`=0 and `clkOut` equals `ssClkIn`. The A word loads on `ssClkIn` rising edges and ignores `sysClk` edges.
- R8: With `dirSel`=1 and `capSel`=1, `ssClkOe`=1, `ssClkOut` and `clkOut` equal `sysClk`. The A word loads on `sysClk` rising edges and ignores `ssClkIn` edges.
- R9: A falling edge of `gateHi` (sampled 1, then 0) loads the current source word. If it falls in the same cycle as a selected-clock rising edge, the result is a single load of that word.
- R10: The A-to-B word loads only while `dirSel`=0, and the B-to-A word only while `dirSel`=1. Both clear to zero on asynchronous reset (`rstN`=0).
- R11: A stored word survives an isolation period (`oeN`=1) and shows again on the destination once `oeN` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dirSel | input | 1 | 0: A to B, 1: B to A |
| oeN | input | 1 | Data output-enable, active low |
| gateHi | input | 1 | 1: transparent and clocks off; 0: registered and clocks on |
| capSel | input | 1 | Receive capture clock: 0 incoming sync clock, 1 system clock |
| sysClk | input | 1 | System clock strobe |
| ssClkIn | input | 1 | Source-synchronous clock from the pad |
| aIn | input | WIDTH | A port data from the pad |
| bIn | input | WIDTH | B port data from the pad |
| aOut | output | WIDTH | A port data toward the pad |
| aOe | output | 1 | A port drive enable |
| bOut | output | WIDTH | B port data toward the pad |
| bOe | output | 1 | B port drive enable |
| ssClkOut | output | 1 | Source-synchronous clock toward the pad |
| ssClkOe | output | 1 | Source-synchronous clock drive enable |
| clkOut | output | 1 | Local forwarded clock |
| clkOutOe | output | 1 | Local forwarded clock enable |

## Verification
Two things can both ask for a load of the same storage word in one cycle: a rising edge of the selected clock, and a falling edge of the clock-gate input. The bench makes them collide. It drops `gateHi` and raises `sysClk` in the same step, with a fresh source word present. It then expects exactly that word on the destination, and that word still held one cycle later after the source has changed.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capAB;     // load the A-to-B word this cycle
    logic capBA;     // load the B-to-A word this cycle
    logic passThru;  // destination follows source combinationally
  } xferStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dirSel,
  input  logic        oeN,
  input  logic        gateHi,
  input  logic        capSel,
  input  logic        sysClk,
  input  logic        ssClkIn,
  output xferStrobe_t strobe,
  output logic        aOe,
  output logic        bOe,
  output logic        ssClkOut,
  output logic        ssClkOe,
  output logic        clkOut,
  output logic        clkOutOe
);
  localparam int NSAMP = 3;

  // Previous samples: {gateHi, ssClkIn, sysClk}
  logic [NSAMP-1:0] curSamp, prevSamp;
  assign curSamp = {gateHi, ssClkIn, sysClk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSamp <= '0;
    else       prevSamp <= curSamp;
  end

  logic sysRise, ssRise, gateFall, useSs, edgeHit, capture;
  assign sysRise  = sysClk  & ~prevSamp[0];
  assign ssRise   = ssClkIn & ~prevSamp[1];
  assign gateFall = ~gateHi & prevSamp[2];
  assign useSs    = dirSel & ~capSel;
  assign edgeHit  = ~gateHi & (useSs ? ssRise : sysRise);
  assign capture  = edgeHit | gateFall;

  always_comb begin
    strobe.capAB    = capture & ~dirSel;
    strobe.capBA    = capture & dirSel;
    strobe.passThru = gateHi;
  end

  assign bOe      = ~oeN & ~dirSel;
  assign aOe      = ~oeN & dirSel;
  assign ssClkOe  = ~gateHi & (~dirSel | capSel);
  assign ssClkOut = sysClk;
  assign clkOutOe = ~gateHi;
  assign clkOut   = useSs ? ssClkIn : sysClk;

  // R5
  full_iso_chk: assert property (@(posedge clk) disable iff (!rstN)
    (oeN && gateHi) |-> (!aOe && !bOe && !ssClkOe && !clkOutOe));
  // R6
  a2b_clk_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dirSel && !gateHi) |-> (ssClkOe && clkOutOe && ssClkOut == sysClk && clkOut == sysClk));
  // R7
  ss_rx_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirSel && !capSel) |-> (!ssClkOe && clkOut == ssClkIn));
  // R10
  dir_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dirSel |-> !strobe.capAB);
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  xferStrobe_t      strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut
);
  localparam int NDIR = 2;

  logic [WIDTH-1:0] srcWord [NDIR];
  logic [WIDTH-1:0] stoWord [NDIR];
  logic [NDIR-1:0]  loadEn;

  assign srcWord[0] = aIn;
  assign srcWord[1] = bIn;
  assign loadEn     = {strobe.capBA, strobe.capAB};

  // One storage word per direction: 0 = A to B, 1 = B to A
  for (genvar d = 0; d < NDIR; d++) begin : g_store
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          stoWord[d] <= '0;
      else if (loadEn[d]) stoWord[d] <= srcWord[d];
    end
  end

  assign bOut = strobe.passThru ? aIn : stoWord[0];
  assign aOut = strobe.passThru ? bIn : stoWord[1];

  // R2
  ab_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capAB |=> (stoWord[0] == $past(aIn)));
  // R2
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capAB |=> $stable(stoWord[0]));
  // R10
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capBA |=> $stable(stoWord[1]));
  // R3
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.passThru |-> (bOut == aIn && aOut == bIn));
endmodule

// File: rtl/bus_xcvr_ctl.sv
module bus_xcvr_ctl
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirSel,
  input  logic             oeN,
  input  logic             gateHi,
  input  logic             capSel,
  input  logic             sysClk,
  input  logic             ssClkIn,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe,
  output logic             ssClkOut,
  output logic             ssClkOe,
  output logic             clkOut,
  output logic             clkOutOe
);
  xferStrobe_t strobe;

  xcvr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dirSel(dirSel), .oeN(oeN), .gateHi(gateHi),
    .capSel(capSel), .sysClk(sysClk), .ssClkIn(ssClkIn), .strobe(strobe),
    .aOe(aOe), .bOe(bOe), .ssClkOut(ssClkOut), .ssClkOe(ssClkOe),
    .clkOut(clkOut), .clkOutOe(clkOutOe)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .bOut(bOut)
  );
endmodule

// File: tb/sim_bus_xcvr_ctl.sv
module sim_bus_xcvr_ctl;
  localparam int W = 18;
  localparam int F_A = 0, F_B = 1, F_EN = 2, F_CK = 3;

  logic clk = 0, rstN = 0;
  logic dirSel = 0, oeN = 1, gateHi = 1, capSel = 0, sysClk = 0, ssClkIn = 0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut;
  logic aOe, bOe, ssClkOut, ssClkOe, clkOut, clkOutOe;

  int checks = 0, errors = 0;
  bit done = 0;

  string         reqQ[$];
  int            fldQ[$];
  logic [W-1:0]  expQ[$];

  always #4 clk = ~clk;

  bus_xcvr_ctl #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .dirSel(dirSel), .oeN(oeN), .gateHi(gateHi),
    .capSel(capSel), .sysClk(sysClk), .ssClkIn(ssClkIn), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe), .ssClkOut(ssClkOut),
    .ssClkOe(ssClkOe), .clkOut(clkOut), .clkOutOe(clkOutOe)
  );

  // Monitor: compare queued expectations against outputs at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (fldQ.size() > 0) begin
        string r;
        int f;
        logic [W-1:0] e, act;
        r = reqQ.pop_front();
        f = fldQ.pop_front();
        e = expQ.pop_front();
        case (f)
          F_A:     act = aOut;
          F_B:     act = bOut;
          F_EN:    act = {{(W-4){1'b0}}, aOe, bOe, ssClkOe, clkOutOe};
          default: act = {{(W-2){1'b0}}, ssClkOut, clkOut};
        endcase
        checks++;
        if (act !== e) begin
          errors++;
          $display("FAIL %s field %0d actual %h expected %h", r, f, act, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  // Driver side: push an expectation, let the monitor judge it
  task automatic expect_out(string r, int f, logic [W-1:0] e);
    reqQ.push_back(r); fldQ.push_back(f); expQ.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic sysPulse();
    sysClk = 1; step(); sysClk = 0; step();
  endtask

  task automatic ssPulse();
    ssClkIn = 1; step(); ssClkIn = 0; step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R5 full isolation during and after reset
    expect_out("R5 reset", F_EN, 18'h0);
    rstN = 1; step();
    expect_out("R5 after reset", F_EN, 18'h0);

    // R10 reset value, R1 direction decode A to B
    gateHi = 0; oeN = 0; step();
    expect_out("R10 reset zero", F_B, 18'h0);
    expect_out("R1 a2b enables", F_EN, 18'b0111);

    // R2 registered load and hold
    aIn = 18'h2A5A5; sysPulse();
    expect_out("R2 load", F_B, 18'h2A5A5);
    aIn = 18'h01234; step(); step();
    expect_out("R2 hold", F_B, 18'h2A5A5);

    // R6 clock forwarding, capSel ignored
    capSel = 1; sysClk = 1; step();
    expect_out("R6 sys hi cms1", F_CK, 18'b11);
    capSel = 0; sysClk = 0; step();
    expect_out("R6 sys lo cms0", F_CK, 18'b00);

    // R3 transparent
    gateHi = 1; step();
    expect_out("R3 pass", F_B, 18'h01234);
    aIn = 18'h3C3C3; #1;
    expect_out("R3 pass follow", F_B, 18'h3C3C3);
    expect_out("R3 clocks off", F_EN, 18'b0100);

    // R9 falling gate captures source
    aIn = 18'h11111; gateHi = 0; step();
    aIn = 18'h22222; step();
    expect_out("R9 gate fall load", F_B, 18'h11111);

    // R9 collision: gate fall and sysClk rise in one cycle
    gateHi = 1; step();
    aIn = 18'h0BEEF; gateHi = 0; sysClk = 1; step();
    aIn = 18'h00F0F; sysClk = 0; step();
    expect_out("R9 collision", F_B, 18'h0BEEF);

    // R4 data isolation keeps clocks and capture
    oeN = 1; step();
    expect_out("R4 iso enables", F_EN, 18'b0011);
    aIn = 18'h35353; sysPulse();
    aIn = 18'h00000;
    oeN = 0; step();
    // R11 stored word reappears
    expect_out("R4 R11 reappear", F_B, 18'h35353);

    // R7 receive with incoming sync clock
    dirSel = 1; capSel = 0; step();
    expect_out("R7 enables", F_EN, 18'b1001);
    bIn = 18'h1ABCD; sysPulse();
    expect_out("R7 sys ignored", F_A, 18'h0);
    ssPulse();
    expect_out("R7 ss load", F_A, 18'h1ABCD);
    ssClkIn = 1; #1;
    expect_out("R7 clkOut follows ss", F_CK, 18'b01);
    ssClkIn = 0; step();

    // R10 A-to-B word untouched while receiving
    aIn = 18'h3FFFF; sysPulse();
    dirSel = 0; step();
    expect_out("R10 a2b kept", F_B, 18'h35353);
    dirSel = 1; step();

    // R8 receive with system clock
    capSel = 1; step();
    expect_out("R8 enables", F_EN, 18'b1011);
    bIn = 18'h2468A; ssPulse();
    expect_out("R8 ss ignored", F_A, 18'h1ABCD);
    sysPulse();
    expect_out("R8 sys load", F_A, 18'h2468A);
    sysClk = 1; #1;
    expect_out("R8 clocks", F_CK, 18'b11);
    sysClk = 0; step();

    // R5 full isolation, then R11 return via data isolation
    oeN = 1; gateHi = 1; step();
    expect_out("R5 full iso", F_EN, 18'h0);
    gateHi = 0; step(); step();
    expect_out("R11 iso enables", F_EN, 18'b0011);
    oeN = 0; step();
    expect_out("R11 a reappear", F_A, 18'h2468A);
    expect_out("R1 b2a enables", F_EN, 18'b1011);

    step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule